// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a low-power single-data-rate SDRAM from reset to the point where normal traffic may begin. While the device settles it holds the command bus idle, with clock-enable and the data masks high, for a fixed pause. It then issues, in order:

- a precharge of every bank;
- a load of the base mode register;
- a load of the extended mode register;
- a parameterized number of auto refresh cycles.

One parameter chooses whether the two register loads come before or after the refreshes.

Every gap the device needs is given in nanoseconds and turned into a whole number of clocks at elaboration. Any fraction of a clock is rounded up.

When the last gap has run out, a sticky done flag tells a normal memory controller that it may take over the pins. The pins are plain control outputs. There is no data stream, and so no valid/ready handshake and no back-pressure. A synchronous reset may arrive at any point and restarts the sequence from the pause.

Top module: `sdram_init_seq`

## Requirements
- R1: During reset and for the whole pause, the command pins {cs_n,ras_n,cas_n,we_n} show NOP (4'b0111), sd_cke and every sd_dqm bit are 1, and init_done is 0. sd_cke and sd_dqm stay 1 throughout the sequence.
- R2: Cycle 0 is the first cycle after reset is released. The first command appears in cycle P, where P = ceil(PAUSE_NS*1000 / CLK_PERIOD_PS).
- R3: The first command is precharge-all. Its code is 4'b0010, sd_addr is 1 in bit 10 only, and sd_ba is 0.
- R4: The base mode load is issued once, with code 4'b0000, sd_ba = 2'b00 and sd_addr = MODE_VAL.
- R5: The extended mode load is issued once, with code 4'b0000, sd_ba = 2'b10 and sd_addr = EXT_VAL.
- R6: Auto refresh (code 4'b0001) is issued exactly max(REF_CNT,2) times.
- R7: With MRS_LAST=0 the order is precharge, mode, extended mode, refreshes. With MRS_LAST=1 it is precharge, refreshes, mode, extended mode.
- R8: Each command lasts one cycle and is followed by NOPs. The next command comes exactly W cycles after it, where W = ceil(t*1000 / CLK_PERIOD_PS) and is at least 1. t is tRP after a precharge, tRC after a refresh and tMRD after either mode load.
- R9: If the last command is in cycle c with gap W, init_done is 1 from cycle c+W onward until reset, and no command is issued after that.
- R10: A synchronous reset restarts the sequence from the pause. Reset wins over a command issue or over the rise of init_done that falls on the same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sd_cke | output | 1 | Clock enable to the device |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | BA_W | Bank address |
| sd_addr | output | ADDR_W | Address, carries mode values and the all-bank bit |
| sd_dqm | output | DQM_W | Data masks, held high |
| init_done | output | 1 | Sequence finished, sticky until reset |

## Verification
The sharpest collision is a synchronous reset landing on the same edge as a step of the sequence.

The bench provokes it twice:

- once on the edge where the final refresh of the default ordering would be issued;
- once on the edge where init_done would rise.

In both cases the cycle after that edge must show the reset state of R1, with NOP, no done flag and the pause restarted, and the following full run must keep its exact cycle schedule.

Random reset lengths and a random abort inside the pause complete the restart checks.

// File: rtl/sdinit_pkg.sv
package sdinit_pkg;

  typedef enum logic [1:0] {
    STEP_PRE  = 2'd0,
    STEP_MRS  = 2'd1,
    STEP_EMRS = 2'd2,
    STEP_REF  = 2'd3
  } step_t;

  typedef enum logic [1:0] {
    PH_PAUSE = 2'd0,
    PH_RUN   = 2'd1,
    PH_DONE  = 2'd2
  } phase_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  localparam logic [1:0] BA_BASE = 2'b00;
  localparam logic [1:0] BA_EXT  = 2'b10;

  // nanoseconds to clocks, fraction rounded up, never below one clock
  function automatic int unsigned ns_to_cycles(input int unsigned ns,
                                               input int unsigned period_ps);
    int unsigned c;
    c = (ns * 1000 + period_ps - 1) / period_ps;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned min3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

endpackage

// File: rtl/sdinit_down_timer.sv
module sdinit_down_timer #(
  parameter int unsigned          W    = 16,
  parameter logic [W-1:0]         INIT = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt_q <= INIT;
    else if (load)         cnt_q <= load_val;
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdinit_step_map.sv
module sdinit_step_map
  import sdinit_pkg::*;
#(
  parameter int unsigned REFS     = 2,
  parameter bit          MRS_LAST = 1'b0,
  parameter int unsigned IDX_W    = 3,
  parameter int unsigned CNT_W    = 16,
  parameter int unsigned TRP_C    = 1,
  parameter int unsigned TRC_C    = 1,
  parameter int unsigned TMRD_C   = 1
) (
  input  logic [IDX_W-1:0] idx,
  output step_t            kind,
  output logic [CNT_W-1:0] wait_m1
);

  localparam logic [CNT_W-1:0] GAP_PRE  = CNT_W'(TRP_C - 1);
  localparam logic [CNT_W-1:0] GAP_REF  = CNT_W'(TRC_C - 1);
  localparam logic [CNT_W-1:0] GAP_MODE = CNT_W'(TMRD_C - 1);
  localparam logic [IDX_W-1:0] REF_END  = IDX_W'(REFS);
  localparam logic [IDX_W-1:0] MRS_POS  = IDX_W'(REFS + 1);

  generate
    if (!MRS_LAST) begin : g_mode_first
      always_comb begin
        if (idx == '0)                kind = STEP_PRE;
        else if (idx == IDX_W'(1))    kind = STEP_MRS;
        else if (idx == IDX_W'(2))    kind = STEP_EMRS;
        else                          kind = STEP_REF;
      end
    end else begin : g_mode_last
      always_comb begin
        if (idx == '0)                kind = STEP_PRE;
        else if (idx <= REF_END)      kind = STEP_REF;
        else if (idx == MRS_POS)      kind = STEP_MRS;
        else                          kind = STEP_EMRS;
      end
    end
  endgenerate

  always_comb begin
    unique case (kind)
      STEP_PRE:  wait_m1 = GAP_PRE;
      STEP_REF:  wait_m1 = GAP_REF;
      default:   wait_m1 = GAP_MODE;
    endcase
  end

endmodule

// File: rtl/sdinit_pin_drive.sv
module sdinit_pin_drive
  import sdinit_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 13,
  parameter int unsigned       BA_W     = 2,
  parameter int unsigned       DQM_W    = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0,
  parameter logic [ADDR_W-1:0] EXT_VAL  = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  step_t             kind,
  output logic [3:0]        cmd,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              cke,
  output logic [DQM_W-1:0]  dqm
);

  localparam int unsigned       ALL_BANK_BIT = 10;
  localparam logic [ADDR_W-1:0] PRE_ADDR     = ADDR_W'(1) << ALL_BANK_BIT;

  logic [3:0]        cmd_d;
  logic [BA_W-1:0]   ba_d;
  logic [ADDR_W-1:0] addr_d;

  always_comb begin
    cmd_d  = CMD_NOP;
    ba_d   = '0;
    addr_d = '0;
    if (issue) begin
      unique case (kind)
        STEP_PRE: begin
          cmd_d  = CMD_PRE;
          addr_d = PRE_ADDR;
        end
        STEP_MRS: begin
          cmd_d  = CMD_LMR;
          ba_d   = BA_W'(BA_BASE);
          addr_d = MODE_VAL;
        end
        STEP_EMRS: begin
          cmd_d  = CMD_LMR;
          ba_d   = BA_W'(BA_EXT);
          addr_d = EXT_VAL;
        end
        default: cmd_d = CMD_REF;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd  <= CMD_NOP;
      ba   <= '0;
      addr <= '0;
      cke  <= 1'b1;
      dqm  <= '1;
    end else begin
      cmd  <= cmd_d;
      ba   <= ba_d;
      addr <= addr_d;
      cke  <= 1'b1;
      dqm  <= '1;
    end
  end

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdinit_pkg::*;
#(
  parameter int unsigned       CLK_PERIOD_PS = 5000,
  parameter int unsigned       PAUSE_NS      = 200000,
  parameter int unsigned       TRP_NS        = 18,
  parameter int unsigned       TRC_NS        = 63,
  parameter int unsigned       TMRD_NS       = 12,
  parameter int unsigned       REF_CNT       = 8,
  parameter bit                MRS_LAST      = 1'b0,
  parameter int unsigned       ADDR_W        = 13,
  parameter int unsigned       BA_W          = 2,
  parameter int unsigned       DQM_W         = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL      = 13'h0033,
  parameter logic [ADDR_W-1:0] EXT_VAL       = 13'h0020
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic              sd_cke,
  output logic              sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [BA_W-1:0]   sd_ba,
  output logic [ADDR_W-1:0] sd_addr,
  output logic [DQM_W-1:0]  sd_dqm,
  output logic              init_done
);

  localparam int unsigned PAUSE_C = ns_to_cycles(PAUSE_NS, CLK_PERIOD_PS);
  localparam int unsigned TRP_C   = ns_to_cycles(TRP_NS, CLK_PERIOD_PS);
  localparam int unsigned TRC_C   = ns_to_cycles(TRC_NS, CLK_PERIOD_PS);
  localparam int unsigned TMRD_C  = ns_to_cycles(TMRD_NS, CLK_PERIOD_PS);
  localparam int unsigned MIN_GAP = min3(TRP_C, TRC_C, TMRD_C);
  localparam int unsigned REFS    = (REF_CNT < 2) ? 2 : REF_CNT;
  localparam int unsigned NSTEPS  = 3 + REFS;
  localparam int unsigned IDX_W   = $clog2(NSTEPS);
  localparam int unsigned MAX_C   = (PAUSE_C > max3(TRP_C, TRC_C, TMRD_C)) ?
                                    PAUSE_C : max3(TRP_C, TRC_C, TMRD_C);
  localparam int unsigned CNT_W   = $clog2(MAX_C + 1);
  localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(NSTEPS - 1);
  localparam logic [CNT_W-1:0] PAUSE_INIT = CNT_W'(PAUSE_C - 1);

  phase_t           phase_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] issue_idx;
  logic             expired;
  logic             issue;
  logic             finish;
  step_t            kind;
  logic [CNT_W-1:0] wait_m1;
  logic [3:0]       cmd;
  logic             done_q;

  assign issue_idx = (phase_q == PH_PAUSE) ? '0 : idx_q + 1'b1;

  always_comb begin
    issue  = 1'b0;
    finish = 1'b0;
    if (expired) begin
      unique case (phase_q)
        PH_PAUSE: issue = 1'b1;
        PH_RUN: begin
          if (idx_q == LAST_IDX) finish = 1'b1;
          else                   issue  = 1'b1;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_PAUSE;
      idx_q   <= '0;
      done_q  <= 1'b0;
    end else if (issue) begin
      phase_q <= PH_RUN;
      idx_q   <= issue_idx;
    end else if (finish) begin
      phase_q <= PH_DONE;
      done_q  <= 1'b1;
    end
  end

  sdinit_down_timer #(
    .W    (CNT_W),
    .INIT (PAUSE_INIT)
  ) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (issue),
    .load_val (wait_m1),
    .expired  (expired)
  );

  sdinit_step_map #(
    .REFS     (REFS),
    .MRS_LAST (MRS_LAST),
    .IDX_W    (IDX_W),
    .CNT_W    (CNT_W),
    .TRP_C    (TRP_C),
    .TRC_C    (TRC_C),
    .TMRD_C   (TMRD_C)
  ) u_map (
    .idx     (issue_idx),
    .kind    (kind),
    .wait_m1 (wait_m1)
  );

  sdinit_pin_drive #(
    .ADDR_W   (ADDR_W),
    .BA_W     (BA_W),
    .DQM_W    (DQM_W),
    .MODE_VAL (MODE_VAL),
    .EXT_VAL  (EXT_VAL)
  ) u_pins (
    .clk   (clk),
    .rst_n (rst_n),
    .issue (issue),
    .kind  (kind),
    .cmd   (cmd),
    .ba    (sd_ba),
    .addr  (sd_addr),
    .cke   (sd_cke),
    .dqm   (sd_dqm)
  );

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign init_done = done_q;

endmodule

// File: rtl/sdram_init_seq_chk.sv
module sdram_init_seq_chk
  import sdinit_pkg::*;
#(
  parameter int unsigned       PAUSE_C  = 1,
  parameter int unsigned       MIN_GAP  = 1,
  parameter int unsigned       ADDR_W   = 13,
  parameter int unsigned       BA_W     = 2,
  parameter int unsigned       DQM_W    = 2,
  parameter logic [ADDR_W-1:0] MODE_VAL = '0,
  parameter logic [ADDR_W-1:0] EXT_VAL  = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        cmd,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              cke,
  input logic [DQM_W-1:0]  dqm,
  input logic              done
);

  logic [31:0] cyc_q;
  logic [15:0] gap_q;
  logic        seen_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cyc_q  <= '0;
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      if (cyc_q != 32'hFFFF_FFFF) cyc_q <= cyc_q + 1'b1;
      if (cmd != CMD_NOP) begin
        gap_q  <= 16'd1;
        seen_q <= 1'b1;
      end else if (gap_q != 16'hFFFF) begin
        gap_q <= gap_q + 1'b1;
      end
    end
  end

  // R1
  pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q < PAUSE_C) |-> (cmd == CMD_NOP && cke && (&dqm) && !done));

  // R2
  first_cmd_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && cmd != CMD_NOP) |-> (cyc_q == PAUSE_C));

  // R3
  first_is_precharge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_q && cmd != CMD_NOP) |-> (cmd == CMD_PRE && addr[10]));

  // R5
  mode_load_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_LMR) |-> ((ba == BA_W'(BA_BASE) && addr == MODE_VAL) ||
                          (ba == BA_W'(BA_EXT)  && addr == EXT_VAL)));

  // R8
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seen_q && cmd != CMD_NOP) |-> (gap_q >= 16'(MIN_GAP)));

  // R9
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);

  // R9
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cmd == CMD_NOP));

endmodule

bind sdram_init_seq sdram_init_seq_chk #(
  .PAUSE_C  (PAUSE_C),
  .MIN_GAP  (MIN_GAP),
  .ADDR_W   (ADDR_W),
  .BA_W     (BA_W),
  .DQM_W    (DQM_W),
  .MODE_VAL (MODE_VAL),
  .EXT_VAL  (EXT_VAL)
) chk (
  .clk   (clk),
  .rst_n (rst_n),
  .cmd   ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .ba    (sd_ba),
  .addr  (sd_addr),
  .cke   (sd_cke),
  .dqm   (sd_dqm),
  .done  (init_done)
);

// File: tb/sdram_init_seq_test.sv
`timescale 1ns/1ps
module sdram_init_seq_test;

  localparam int PERIOD_PS = 5000;
  localparam int PAUSE_NS  = 200000;
  localparam int TRP_NS    = 18;
  localparam int TRC_NS    = 63;
  localparam int TMRD_NS   = 12;
  localparam int REF_CNT   = 8;
  localparam logic [12:0] MODE_V = 13'h0033;
  localparam logic [12:0] EXT_V  = 13'h0020;

  function automatic int to_cyc(input int ns);
    int c;
    c = (ns * 1000 + PERIOD_PS - 1) / PERIOD_PS;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int P_C    = (PAUSE_NS * 1000 + PERIOD_PS - 1) / PERIOD_PS;
  localparam int NSTEPS = 3 + REF_CNT;

  // step kinds: 0 precharge, 1 mode, 2 extended mode, 3 refresh
  function automatic int exp_kind(input int order, input int i);
    if (i == 0) return 0;
    if (order == 0) return (i == 1) ? 1 : (i == 2) ? 2 : 3;
    if (i <= REF_CNT) return 3;
    return (i == REF_CNT + 1) ? 1 : 2;
  endfunction

  function automatic int exp_gap(input int k);
    if (k == 0) return to_cyc(TRP_NS);
    if (k == 3) return to_cyc(TRC_NS);
    return to_cyc(TMRD_NS);
  endfunction

  function automatic int done_cycle();
    int t;
    t = P_C;
    for (int i = 0; i < NSTEPS; i++) t += exp_gap(exp_kind(0, i));
    return t;
  endfunction

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        cke_a, cs_a, ras_a, cas_a, we_a, done_a;
  logic [1:0]  ba_a, dqm_a;
  logic [12:0] addr_a;
  logic        cke_b, cs_b, ras_b, cas_b, we_b, done_b;
  logic [1:0]  ba_b, dqm_b;
  logic [12:0] addr_b;

  sdram_init_seq #(.CLK_PERIOD_PS(PERIOD_PS), .PAUSE_NS(PAUSE_NS), .TRP_NS(TRP_NS),
    .TRC_NS(TRC_NS), .TMRD_NS(TMRD_NS), .REF_CNT(REF_CNT), .MRS_LAST(1'b0),
    .MODE_VAL(MODE_V), .EXT_VAL(EXT_V)) uut (
    .clk(clk), .rst_n(rst_n), .sd_cke(cke_a), .sd_cs_n(cs_a), .sd_ras_n(ras_a),
    .sd_cas_n(cas_a), .sd_we_n(we_a), .sd_ba(ba_a), .sd_addr(addr_a),
    .sd_dqm(dqm_a), .init_done(done_a));

  sdram_init_seq #(.CLK_PERIOD_PS(PERIOD_PS), .PAUSE_NS(PAUSE_NS), .TRP_NS(TRP_NS),
    .TRC_NS(TRC_NS), .TMRD_NS(TMRD_NS), .REF_CNT(REF_CNT), .MRS_LAST(1'b1),
    .MODE_VAL(MODE_V), .EXT_VAL(EXT_V)) uut_alt (
    .clk(clk), .rst_n(rst_n), .sd_cke(cke_b), .sd_cs_n(cs_b), .sd_ras_n(ras_b),
    .sd_cas_n(cas_b), .sd_we_n(we_b), .sd_ba(ba_b), .sd_addr(addr_b),
    .sd_dqm(dqm_b), .init_done(done_b));

  int checks = 0;
  int errors = 0;
  int nxt_step [2];
  int nxt_cyc  [2];
  int refs     [2];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, expv, $time);
    end
  endtask

  task automatic observe(input int d, input int n, input logic [3:0] c,
                         input logic [12:0] a, input logic [1:0] b,
                         input logic k, input logic [1:0] m, input logic dn);
    int kd;
    logic [3:0]  ec;
    logic [12:0] ea;
    logic [1:0]  eb;
    string tag;
    chk(k == 1'b1 && m == 2'b11, "R1", "cke/dqm", {k, m}, 3'b111);
    if (n == 0)
      chk(c == 4'b0111 && dn == 1'b0, "R10", "state after reset", {dn, c}, 5'b00111);
    if (nxt_step[d] < NSTEPS && n == nxt_cyc[d]) begin
      kd = exp_kind(d, nxt_step[d]);
      case (kd)
        0: begin ec = 4'b0010; ea = 13'h0400; eb = 2'b00; tag = "R3"; end
        1: begin ec = 4'b0000; ea = MODE_V;   eb = 2'b00; tag = "R4"; end
        2: begin ec = 4'b0000; ea = EXT_V;    eb = 2'b10; tag = "R5"; end
        default: begin ec = 4'b0001; ea = a; eb = b; tag = "R6"; end
      endcase
      if (nxt_step[d] == 0) chk(c == ec, "R2", "command at end of pause", c, ec);
      chk(c == ec, (d == 1) ? "R7" : tag, "command code", c, ec);
      chk(a == ea && b == eb, tag, "address/bank", {b, a}, {eb, ea});
      if (kd == 3 && c == 4'b0001) refs[d]++;
      nxt_cyc[d] += exp_gap(kd);
      nxt_step[d]++;
    end else begin
      chk(c == 4'b0111, (n < P_C) ? "R1" : "R8", "expected NOP", c, 4'b0111);
    end
    chk(dn == (nxt_step[d] == NSTEPS && n >= nxt_cyc[d]), "R9", "init_done",
        dn, (nxt_step[d] == NSTEPS && n >= nxt_cyc[d]));
  endtask

  task automatic run_seq(input int max_n, input bit full);
    rst_n = 1'b0;
    repeat ($urandom_range(1, 4)) @(negedge clk);
    rst_n = 1'b1;
    for (int d = 0; d < 2; d++) begin
      nxt_step[d] = 0;
      nxt_cyc[d]  = P_C;
      refs[d]     = 0;
    end
    for (int n = 0; n < max_n; n++) begin
      observe(0, n, {cs_a, ras_a, cas_a, we_a}, addr_a, ba_a, cke_a, dqm_a, done_a);
      observe(1, n, {cs_b, ras_b, cas_b, we_b}, addr_b, ba_b, cke_b, dqm_b, done_b);
      @(negedge clk);
    end
    if (full) begin
      for (int d = 0; d < 2; d++) begin
        chk(nxt_step[d] == NSTEPS, "R7", "all steps seen", nxt_step[d], NSTEPS);
        chk(refs[d] == REF_CNT, "R6", "refresh count", refs[d], REF_CNT);
      end
    end
  endtask

  initial begin
    int dc;
    void'($urandom(32'd1977));
    dc = done_cycle();
    @(negedge clk);
    // full sequence, both orderings
    run_seq(dc + 20, 1'b1);
    // R10: reset lands on the edge where init_done would rise
    run_seq(dc - 1, 1'b0);
    // R10: reset lands on the edge of the final refresh of uut
    run_seq(dc - to_cyc(TRC_NS) - 1, 1'b0);
    // R10: random abort inside the pause
    run_seq($urandom_range(1, 2000), 1'b0);
    // full sequence after all restarts
    run_seq(dc + 20, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (198000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule